// File: doc/BRIEF.md
# Precision-Fusible Mantissa Multiplier

This block multiplies an unsigned 8-bit activation mantissa word by an unsigned 8-bit weight mantissa word. It is built from a fixed grid of 2-bit by 2-bit multiplier cells. A run-time mode code changes how the cell outputs are grouped. The same cells can form one full-width product, or they can form several narrower, independent products in the same cycle. Each narrow activation field is reused against every weight field in the word, and each weight field against every activation field. A mode of A bits by B bits therefore yields (8/A)·(8/B) products.

The supported operand widths are 8, 4 and 2 bits. The four modes use the same cells and the same output register. The products are packed contiguously into one result vector. Each product takes A+B bits, and any bits above the last product are zero. The result is registered, and a valid flag travels alongside it. Exponent handling, accumulation and data movement between processing elements are left to the surrounding datapath.

Top module: `fuse_mant_mul`

## Requirements
- R1: Mode code 0 selects 8×8. The 16-bit product act·wgt appears in result bits [15:0], and bits [47:16] are zero.
- R2: Mode code 1 selects 8×4. The whole act word multiplies each 4-bit weight field. Weight field n is wgt[4n+3:4n], and its 12-bit product goes to bits [12n+11:12n]. Bits [47:24] are zero.
- R3: Mode code 2 selects 4×4. Activation field m is act[4m+3:4m], and weight field n is wgt[4n+3:4n]. The 8-bit product of field m and field n goes to slot 2n+m, at bits [8s+7:8s].
- R4: Mode code 3 selects 4×2. Activation field m is act[4m+3:4m], and weight field n is wgt[2n+1:2n]. The 6-bit product goes to slot 2n+m, at bits [6s+5:6s], for all eight slots.
- R5: A word presented with in_vld high at a rising edge appears on prod_out at that edge. out_vld is high for exactly the following cycle.
- R6: While in_vld is low, prod_out keeps its last value whatever act, wgt and mode do, and out_vld is low.
- R7: While reset is asserted, prod_out is zero and out_vld is low.
- R8: All operands are treated as unsigned. When every field holds its maximum value, no product disturbs a neighbouring slot in any mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Capture enable for the operand words |
| mode | input | 2 | Precision mode code (0: 8×8, 1: 8×4, 2: 4×4, 3: 4×2) |
| act | input | 8 | Activation mantissa word |
| wgt | input | 8 | Weight mantissa word |
| out_vld | output | 1 | Result valid, one cycle after capture |
| prod_out | output | 48 | Packed products |

## Verification
The assertions assume that act, wgt and mode are settled before each rising edge. They also assume these inputs are driven only with known values while in_vld is high, because each check compares the result with the inputs captured at the previous edge. The stimulus changes every input at the falling edge, so the inputs are always stable at capture. During the hold cycles, the stimulus deliberately changes the operands and the mode while in_vld is low, to confirm that the held result does not depend on them.

// File: rtl/fmm_pkg.sv
package fmm_pkg;

  typedef enum logic [1:0] {
    MODE_A8W8 = 2'd0,
    MODE_A8W4 = 2'd1,
    MODE_A4W4 = 2'd2,
    MODE_A4W2 = 2'd3
  } fmm_mode_e;

  // log2 of the activation field width for a mode, given log2 of the word width
  function automatic int fmm_act_lg(logic [1:0] m, int lg);
    return (m == MODE_A8W8 || m == MODE_A8W4) ? lg : lg - 1;
  endfunction

  // log2 of the weight field width for a mode
  function automatic int fmm_wgt_lg(logic [1:0] m, int lg);
    int r;
    case (m)
      MODE_A8W8: r = lg;
      MODE_A8W4,
      MODE_A4W4: r = lg - 1;
      default:   r = lg - 2;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/fmm_cell.sv
module fmm_cell #(
  parameter int CW = 2
) (
  input  logic [CW-1:0]   a,
  input  logic [CW-1:0]   b,
  output logic [2*CW-1:0] p
);
  assign p = {{CW{1'b0}}, a} * {{CW{1'b0}}, b};
endmodule

// File: rtl/fmm_combine.sv
module fmm_combine
  import fmm_pkg::*;
#(
  parameter int W  = 8,
  parameter int CW = 2
) (
  input  logic [1:0]                            mode,
  input  logic [(W/CW)*(W/CW)*2*CW-1:0]         cells,
  output logic [8*2*W-1:0]                      slots
);
  localparam int NC = W / CW;
  localparam int PW = 2 * CW;
  localparam int SW = 2 * W;
  localparam int NS = 8;
  localparam int LW = $clog2(W);

  logic [SW-1:0] acc [NS];
  int la, lw, ga, gw, oa, ow, s;

  // each cell is weighted by its position inside its group and summed into
  // the group's slot; groups never share an adder, so no carry crosses slots
  always_comb begin
    la = fmm_act_lg(mode, LW);
    lw = fmm_wgt_lg(mode, LW);
    ga = 0; gw = 0; oa = 0; ow = 0; s = 0;
    for (int k = 0; k < NS; k++) acc[k] = '0;
    for (int i = 0; i < NC; i++) begin
      for (int j = 0; j < NC; j++) begin
        ga = (i * CW) >> la;
        oa = (i * CW) & ((1 << la) - 1);
        gw = (j * CW) >> lw;
        ow = (j * CW) & ((1 << lw) - 1);
        s  = (gw << (LW - la)) + ga;
        acc[s] = acc[s] + (SW'(cells[(i*NC+j)*PW +: PW]) << (oa + ow));
      end
    end
  end

  always_comb begin
    for (int k = 0; k < NS; k++) slots[k*SW +: SW] = acc[k];
  end
endmodule

// File: rtl/fmm_pack.sv
module fmm_pack
  import fmm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [1:0]       mode,
  input  logic [8*2*W-1:0] slots,
  output logic [6*W-1:0]   vec
);
  localparam int SW = 2 * W;
  localparam int NS = 8;
  localparam int OW = 6 * W;
  localparam int LW = $clog2(W);

  int psz;

  always_comb begin
    psz = (1 << fmm_act_lg(mode, LW)) + (1 << fmm_wgt_lg(mode, LW));
    vec = '0;
    for (int k = 0; k < NS; k++) begin
      vec = vec | (OW'(slots[k*SW +: SW]) << (k * psz));
    end
  end
endmodule

// File: rtl/fuse_mant_mul.sv
module fuse_mant_mul
  import fmm_pkg::*;
#(
  parameter int W  = 8,
  parameter int CW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_vld,
  input  logic [1:0]     mode,
  input  logic [W-1:0]   act,
  input  logic [W-1:0]   wgt,
  output logic           out_vld,
  output logic [6*W-1:0] prod_out
);
  localparam int NC = W / CW;
  localparam int PW = 2 * CW;
  localparam int OW = 6 * W;

  logic [NC*NC*PW-1:0] cells;
  logic [8*2*W-1:0]    slots;
  logic [OW-1:0]       packed_w;
  logic [OW-1:0]       prod_d, prod_q;
  logic                vld_d, vld_q;

  for (genvar i = 0; i < NC; i++) begin : g_row
    for (genvar j = 0; j < NC; j++) begin : g_col
      fmm_cell #(.CW(CW)) u_cell (
        .a (act[i*CW +: CW]),
        .b (wgt[j*CW +: CW]),
        .p (cells[(i*NC+j)*PW +: PW])
      );
    end
  end

  fmm_combine #(.W(W), .CW(CW)) u_comb (
    .mode  (mode),
    .cells (cells),
    .slots (slots)
  );

  fmm_pack #(.W(W)) u_pack (
    .mode  (mode),
    .slots (slots),
    .vec   (packed_w)
  );

  always_comb begin
    vld_d  = in_vld;
    prod_d = in_vld ? packed_w : prod_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      prod_q <= '0;
    end else begin
      vld_q  <= vld_d;
      prod_q <= prod_d;
    end
  end

  assign out_vld  = vld_q;
  assign prod_out = prod_q;
endmodule

// File: rtl/fmm_chk.sv
module fmm_chk #(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_vld,
  input logic [1:0]     mode,
  input logic [W-1:0]   act,
  input logic [W-1:0]   wgt,
  input logic           out_vld,
  input logic [6*W-1:0] prod_out
);
  localparam int H = W / 2;

  assert_valid_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);

  assert_valid_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> $stable(prod_out));

  assert_full_prod_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && mode == 2'd0) |=>
      prod_out[2*W-1:0] == ($past(act) * $past(wgt)));

  assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && mode == 2'd0) |=> prod_out[6*W-1:2*W] == '0);

  assert_zero_field_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && mode == 2'd2 && act[H-1:0] == '0) |=>
      (prod_out[W-1:0] == '0 && prod_out[3*W-1:2*W] == '0));
endmodule

bind fuse_mant_mul fmm_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_vld   (in_vld),
  .mode     (mode),
  .act      (act),
  .wgt      (wgt),
  .out_vld  (out_vld),
  .prod_out (prod_out)
);

// File: tb/sim_fuse_mant_mul.sv
`timescale 1ns/1ps
module sim_fuse_mant_mul;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_vld;
  logic [1:0]  mode;
  logic [7:0]  act, wgt;
  logic        out_vld;
  logic [47:0] prod_out;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  fuse_mant_mul u0 (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .mode(mode),
    .act(act), .wgt(wgt), .out_vld(out_vld), .prod_out(prod_out)
  );

  function automatic logic [47:0] ref_mul(logic [1:0] m, logic [7:0] a, logic [7:0] w);
    int pa, pw, na, nw;
    logic [47:0] r;
    logic [7:0] x, y;
    pa = (m <= 2'd1) ? 8 : 4;
    pw = (m == 2'd0) ? 8 : (m == 2'd3) ? 2 : 4;
    na = 8 / pa;
    nw = 8 / pw;
    r = '0;
    for (int wi = 0; wi < nw; wi++) begin
      for (int ai = 0; ai < na; ai++) begin
        x = 8'((a >> (ai*pa)) & ((1 << pa) - 1));
        y = 8'((w >> (wi*pw)) & ((1 << pw) - 1));
        r = r | (48'(16'(x) * 16'(y)) << ((wi*na + ai) * (pa + pw)));
      end
    end
    return r;
  endfunction

  function automatic string req_of(logic [1:0] m);
    case (m)
      2'd0: return "R1";
      2'd1: return "R2";
      2'd2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(string req, logic [47:0] got, logic [47:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // capture at one falling edge, check at the next (R5)
  task automatic run(logic [1:0] m, logic [7:0] a, logic [7:0] w, bit hold, string tag);
    logic [47:0] e;
    e = ref_mul(m, a, w);
    @(negedge clk);
    in_vld = 1'b1; mode = m; act = a; wgt = w;
    @(negedge clk);
    chk(tag, prod_out, e);
    chk("R5", {47'd0, out_vld}, 48'd1);
    in_vld = 1'b0;
    if (hold) begin
      act = ~a; wgt = a ^ w; mode = m + 2'd1;
      @(negedge clk);
      chk("R6", prod_out, e);
      chk("R6", {47'd0, out_vld}, 48'd0);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h5eed_0042);
    rst_n = 1'b0; in_vld = 1'b0; mode = 2'd0; act = 8'h5a; wgt = 8'ha5;
    repeat (3) @(negedge clk);
    chk("R7", prod_out, 48'd0);
    chk("R7", {47'd0, out_vld}, 48'd0);
    rst_n = 1'b1;

    // directed corners
    run(2'd0, 8'hff, 8'hff, 1'b1, "R1");
    run(2'd0, 8'h00, 8'h9c, 1'b0, "R1");
    run(2'd1, 8'hff, 8'hff, 1'b1, "R8");
    run(2'd1, 8'h80, 8'h1f, 1'b0, "R2");
    run(2'd2, 8'hff, 8'hff, 1'b1, "R8");
    run(2'd2, 8'hf0, 8'h3c, 1'b0, "R3");
    run(2'd3, 8'hff, 8'hff, 1'b1, "R8");
    run(2'd3, 8'h0f, 8'he4, 1'b0, "R4");
    run(2'd3, 8'h00, 8'hff, 1'b0, "R4");

    // random mix over every mode
    for (int n = 0; n < 400; n++) begin
      logic [1:0] m;
      m = 2'($urandom_range(0, 3));
      run(m, 8'($urandom), 8'($urandom), (n % 8) == 0, req_of(m));
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule